// File: doc/BRIEF.md
# Priority Collector with Reciprocal and Hysteresis Mode Switch

This block drains three source queues and turns each fetched radius-squared value into a fixed-point reciprocal. Source 0 belongs to the dedicated distance unit and always wins. The two flexible sources follow it, and when both of them have data the lower index goes first. Lower sources may starve.

Each fetched value goes through an iterative restoring divider that computes floor(2^32 / d). The result goes to the primary output queue. When the primary queue's level is above a spill threshold, the result goes to a secondary queue that feeds a flexible unit instead. If the chosen queue is full, the block holds the result and fetches nothing new.

Separately, the secondary queue's level is checked every cycle to drive a mode flag with hysteresis. The flag switches the flexible unit to accumulate mode when the level is above an upper threshold. It returns to distance mode only when the level falls below a lower threshold.

Top module: `recipCollector`

## Requirements
- R1: After reset, `srcRd`, `priWr` and `secWr` are low and `modeAcc` is 0 (distance mode).
- R2: A source is read only while its `srcEmpty` bit is low. At most one `srcRd` bit is high per cycle. No new read happens until the previous item's result has been written.
- R3: When several sources hold data, source 0 is read first, then source 1, then source 2. A source is read only while every lower-index source is empty.
- R4: The written result is floor(2^32 / d) for a 32-bit input d ≥ 2. Inputs 0 and 1 produce 0xFFFFFFFF.
- R5: A result goes to the primary port when `priLevel` ≤ 128 at write time, and to the secondary port when `priLevel` > 128.
- R6: While the chosen queue's full flag is high, no write occurs and no source is read. The held result is written once the flag drops.
- R7: Each accepted item produces exactly one write. `priWr` and `secWr` are never high together.
- R8: `modeAcc` rises one cycle after `secLevel` > 128 is presented. It does not rise at exactly 128.
- R9: Once set, `modeAcc` stays 1 for any `secLevel` from 32 upward. It clears one cycle after `secLevel` < 32 is presented, and stays 0 for any level up to 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcEmpty | input | 3 | Empty flag of each source queue (bit 0 = distance unit) |
| srcData | input | 96 | Head word of each source queue; source i at bits [32i+31:32i] |
| srcRd | output | 3 | Pop strobe for each source queue |
| priLevel | input | 11 | Fill level of the primary output queue |
| priFull | input | 1 | Primary queue full |
| priWr | output | 1 | Primary queue write strobe |
| priData | output | 32 | Reciprocal written to the primary queue |
| secLevel | input | 11 | Fill level of the secondary queue |
| secFull | input | 1 | Secondary queue full |
| secWr | output | 1 | Secondary queue write strobe |
| secData | output | 32 | Reciprocal written to the secondary queue |
| modeAcc | output | 1 | 1 = flexible unit in accumulate mode, 0 = distance mode |

## Verification
The reciprocal is tried with divisors from several groups:
- 0 and 1, which separate the saturation path from the ordinary quotient.
- Powers of two and the values on either side of them, which expose off-by-one errors in the remainder compare.
- A spread of scrambled 32-bit values, which checks every quotient bit position.

Priority is tested by loading all three queues at once, so that the recorded pop order shows any reordering. Routing is tested with `priLevel` at exactly 128 and 129, which separates ≥ from >. Both full flags are held high to show stalling. The secondary level is stepped across 128/129 and 31/32 in both directions, which distinguishes real hysteresis from a single threshold.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_EMIT = 2'd2
  } rcState_t;

  typedef struct packed {
    logic load;
    logic step;
    logic first;
  } rcStrobe_t;
endpackage

// File: rtl/rc_datapath.sv
module rc_datapath
  import rc_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NSRC = 3,
  localparam int SW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  rcStrobe_t          strobe,
  input  logic [SW-1:0]      selIdx,
  input  logic [NSRC*DW-1:0] srcData,
  output logic [DW-1:0]      result
);
  logic [DW-1:0] divisor;
  logic [DW-1:0] rem;
  logic [DW:0]   quot;
  logic [DW:0]   remShift;
  logic          fits;
  logic [DW-1:0] picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < NSRC; i++)
      if (selIdx == SW'(i)) picked = srcData[i*DW +: DW];
  end

  // dividend is 2^DW: only the very first shifted-in bit is one
  assign remShift = {rem, strobe.first};
  assign fits     = remShift >= {1'b0, divisor};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divisor <= '0;
      rem     <= '0;
      quot    <= '0;
    end else if (strobe.load) begin
      divisor <= picked;
      rem     <= '0;
      quot    <= '0;
    end else if (strobe.step) begin
      if (fits) begin
        rem  <= DW'(remShift - {1'b0, divisor});
        quot <= {quot[DW-1:0], 1'b1};
      end else begin
        rem  <= remShift[DW-1:0];
        quot <= {quot[DW-1:0], 1'b0};
      end
    end
  end

  assign result = (divisor == '0 || quot[DW]) ? '1 : quot[DW-1:0];

  // R4: remainder always stays below a nonzero divisor after a step
  p_rem_below_div_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.step) && divisor != '0 |-> rem < divisor);
endmodule

// File: rtl/rc_ctrl.sv
module rc_ctrl
  import rc_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NSRC  = 3,
  parameter int LVW   = 11,
  parameter int SPILL = 128,
  parameter int MODEHI = 128,
  parameter int MODELO = 32,
  localparam int SW    = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int STEPS = DW + 1,
  localparam int CW    = $clog2(STEPS + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] srcEmpty,
  output logic [NSRC-1:0] srcRd,
  input  logic [LVW-1:0]  priLevel,
  input  logic            priFull,
  output logic            priWr,
  input  logic [LVW-1:0]  secLevel,
  input  logic            secFull,
  output logic            secWr,
  output logic            modeAcc,
  output rcStrobe_t       strobe,
  output logic [SW-1:0]   selIdx
);
  rcState_t      state, stateNext;
  logic [CW-1:0] stepCnt;
  logic          anyReady;
  logic          toSec;
  logic          blocked;

  // fixed priority, lowest index wins
  always_comb begin
    selIdx   = '0;
    anyReady = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (!srcEmpty[i]) begin
        selIdx   = SW'(i);
        anyReady = 1'b1;
      end
    end
  end

  assign toSec   = priLevel > LVW'(SPILL);
  assign blocked = toSec ? secFull : priFull;

  always_comb begin
    stateNext    = state;
    strobe       = '0;
    srcRd        = '0;
    priWr        = 1'b0;
    secWr        = 1'b0;
    unique case (state)
      ST_IDLE: if (anyReady) begin
        strobe.load   = 1'b1;
        srcRd[selIdx] = 1'b1;
        stateNext     = ST_CALC;
      end
      ST_CALC: begin
        strobe.step  = 1'b1;
        strobe.first = (stepCnt == '0);
        if (stepCnt == CW'(STEPS - 1)) stateNext = ST_EMIT;
      end
      ST_EMIT: if (!blocked) begin
        priWr     = !toSec;
        secWr     = toSec;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      state   <= stateNext;
      stepCnt <= (state == ST_CALC) ? stepCnt + CW'(1) : '0;
    end
  end

  // two-threshold mode flag on the secondary level
  always_ff @(posedge clk) begin
    if (!rstN)
      modeAcc <= 1'b0;
    else if (!modeAcc && secLevel > LVW'(MODEHI))
      modeAcc <= 1'b1;
    else if (modeAcc && secLevel < LVW'(MODELO))
      modeAcc <= 1'b0;
  end

  p_one_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(srcRd));
  p_read_nonempty_r2: assert property (@(posedge clk) disable iff (!rstN)
    (srcRd & srcEmpty) == '0);
  p_prio_src1_r3: assert property (@(posedge clk) disable iff (!rstN)
    srcRd[1] |-> srcEmpty[0]);
  p_no_full_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (priWr |-> !priFull) and (secWr |-> !secFull));
  p_single_port_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(priWr && secWr));
  p_rise_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeAcc) |-> $past(secLevel) > LVW'(MODEHI));
  p_fall_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(modeAcc) |-> $past(secLevel) < LVW'(MODELO));
endmodule

// File: rtl/recipCollector.sv
module recipCollector
  import rc_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NSRC   = 3,
  parameter int LVW    = 11,
  parameter int SPILL  = 128,
  parameter int MODEHI = 128,
  parameter int MODELO = 32,
  localparam int SW    = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NSRC-1:0]    srcEmpty,
  input  logic [NSRC*DW-1:0] srcData,
  output logic [NSRC-1:0]    srcRd,
  input  logic [LVW-1:0]     priLevel,
  input  logic               priFull,
  output logic               priWr,
  output logic [DW-1:0]      priData,
  input  logic [LVW-1:0]     secLevel,
  input  logic               secFull,
  output logic               secWr,
  output logic [DW-1:0]      secData,
  output logic               modeAcc
);
  rcStrobe_t     strobe;
  logic [SW-1:0] selIdx;
  logic [DW-1:0] result;

  rc_ctrl #(
    .DW(DW), .NSRC(NSRC), .LVW(LVW), .SPILL(SPILL),
    .MODEHI(MODEHI), .MODELO(MODELO)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .srcEmpty(srcEmpty), .srcRd(srcRd),
    .priLevel(priLevel), .priFull(priFull), .priWr(priWr),
    .secLevel(secLevel), .secFull(secFull), .secWr(secWr),
    .modeAcc(modeAcc), .strobe(strobe), .selIdx(selIdx)
  );

  rc_datapath #(.DW(DW), .NSRC(NSRC)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selIdx(selIdx),
    .srcData(srcData), .result(result)
  );

  assign priData = result;
  assign secData = result;
endmodule

// File: tb/tb_recipCollector.sv
module tb_recipCollector;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  srcEmpty;
  logic [95:0] srcData;
  logic [2:0]  srcRd;
  logic [10:0] priLevel = '0;
  logic        priFull = 1'b0;
  logic        priWr;
  logic [31:0] priData;
  logic [10:0] secLevel = '0;
  logic        secFull = 1'b0;
  logic        secWr;
  logic [31:0] secData;
  logic        modeAcc;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  recipCollector dut (
    .clk(clk), .rstN(rstN), .srcEmpty(srcEmpty), .srcData(srcData),
    .srcRd(srcRd), .priLevel(priLevel), .priFull(priFull), .priWr(priWr),
    .priData(priData), .secLevel(secLevel), .secFull(secFull),
    .secWr(secWr), .secData(secData), .modeAcc(modeAcc)
  );

  // behavioural source queues
  logic [31:0] srcMem [3][64];
  logic [5:0]  head [3];
  logic [5:0]  tail [3];
  int          popLog [256];
  int          popCnt = 0;
  logic [31:0] priLog [256];
  logic [31:0] secLog [256];
  int          priCnt = 0;
  int          secCnt = 0;

  initial for (int i = 0; i < 3; i++) begin head[i] = '0; tail[i] = '0; end

  always_comb
    for (int i = 0; i < 3; i++) begin
      srcEmpty[i] = head[i] == tail[i];
      srcData[i*32 +: 32] = srcMem[i][head[i]];
    end

  always @(posedge clk) begin
    for (int i = 0; i < 3; i++)
      if (srcRd[i] && head[i] != tail[i]) begin
        head[i] <= head[i] + 6'd1;
        popLog[popCnt] <= i;
        popCnt <= popCnt + 1;
      end
    if (priWr) begin priLog[priCnt] <= priData; priCnt <= priCnt + 1; end
    if (secWr) begin secLog[secCnt] <= secData; secCnt <= secCnt + 1; end
  end

  task automatic push(int s, logic [31:0] v);
    srcMem[s][tail[s]] = v;
    tail[s] = tail[s] + 6'd1;
  endtask

  function automatic logic [31:0] expRecip(logic [31:0] d);
    logic [63:0] q;
    if (d == 0) return 32'hFFFF_FFFF;
    q = 64'h1_0000_0000 / {32'd0, d};
    return (q > 64'hFFFF_FFFF) ? 32'hFFFF_FFFF : q[31:0];
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitWrites(int target);
    for (int k = 0; k < 60 * 40; k++) begin
      if (priCnt + secCnt >= target) break;
      @(negedge clk);
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [31:0] divs [48];

  initial begin
    int base;
    int pc;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(srcRd == 0 && !priWr && !secWr, "R1 strobes", {srcRd, priWr, secWr}, 0);
    check(modeAcc == 0, "R1 mode", modeAcc, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R4: reciprocal sweep through source 0, primary port
    divs[0] = 0; divs[1] = 1; divs[2] = 2; divs[3] = 3;
    divs[4] = 7; divs[5] = 255; divs[6] = 256; divs[7] = 257;
    divs[8] = 32'h0001_0000; divs[9] = 32'h0000_FFFF;
    divs[10] = 32'h8000_0000; divs[11] = 32'h8000_0001;
    divs[12] = 32'hFFFF_FFFF; divs[13] = 32'h7FFF_FFFF;
    divs[14] = 32'h4000_0000; divs[15] = 32'h3FFF_FFFF;
    for (int k = 16; k < 48; k++)
      divs[k] = (32'(k) * 32'h9E37_79B1) ^ (32'(k) << 5);
    for (int k = 0; k < 48; k++) begin
      base = priCnt;
      push(0, divs[k]);
      waitWrites(base + secCnt + 1);
      @(negedge clk);
      check(priLog[base] == expRecip(divs[k]), "R4 reciprocal",
            priLog[base], expRecip(divs[k]));
    end
    check(secCnt == 0, "R5 low level stays primary", secCnt, 0);

    // R3: priority with all three queues loaded at once
    pc = popCnt;
    base = priCnt;
    push(2, 32'd11); push(2, 32'd13);
    push(1, 32'd17); push(1, 32'd19);
    push(0, 32'd23); push(0, 32'd29);
    waitWrites(priCnt + secCnt + 6);
    @(negedge clk);
    for (int k = 0; k < 6; k++)
      check(popLog[pc + k] == k / 2, "R3 pop order", popLog[pc + k], k / 2);
    check(priLog[base] == expRecip(23), "R3 first data", priLog[base], expRecip(23));
    check(priLog[base + 5] == expRecip(13), "R3 last data", priLog[base + 5], expRecip(13));
    check(priCnt - base == 6, "R7 one write each", priCnt - base, 6);

    // R5: routing at threshold edge
    priLevel = 11'd128;
    base = priCnt;
    push(1, 32'd7);
    waitWrites(priCnt + secCnt + 1);
    @(negedge clk);
    check(priCnt == base + 1 && priLog[base] == expRecip(7), "R5 level 128 primary",
          priLog[base], expRecip(7));
    priLevel = 11'd129;
    base = secCnt;
    push(2, 32'd9);
    waitWrites(priCnt + secCnt + 1);
    @(negedge clk);
    check(secCnt == base + 1 && secLog[base] == expRecip(9), "R5 level 129 secondary",
          secLog[base], expRecip(9));

    // R6: stall on full primary
    priLevel = 11'd5;
    priFull = 1'b1;
    pc = popCnt;
    base = priCnt + secCnt;
    push(0, 32'd3); push(0, 32'd5);
    repeat (120) @(negedge clk);
    check(priCnt + secCnt == base, "R6 no write while full", priCnt + secCnt, base);
    check(popCnt - pc == 1, "R6 no new read while full", popCnt - pc, 1);
    priFull = 1'b0;
    waitWrites(base + 2);
    @(negedge clk);
    check(priLog[priCnt - 2] == expRecip(3), "R6 held result", priLog[priCnt - 2], expRecip(3));
    check(priLog[priCnt - 1] == expRecip(5), "R6 next result", priLog[priCnt - 1], expRecip(5));

    // R6: stall on full secondary
    priLevel = 11'd300;
    secFull = 1'b1;
    base = priCnt + secCnt;
    push(1, 32'd100);
    repeat (80) @(negedge clk);
    check(priCnt + secCnt == base, "R6 secondary full stall", priCnt + secCnt, base);
    secFull = 1'b0;
    waitWrites(base + 1);
    @(negedge clk);
    check(secLog[secCnt - 1] == expRecip(100), "R6 secondary release",
          secLog[secCnt - 1], expRecip(100));

    // R8 / R9: hysteresis
    secLevel = 11'd128; @(negedge clk);
    check(modeAcc == 0, "R8 no rise at 128", modeAcc, 0);
    secLevel = 11'd129; @(negedge clk);
    check(modeAcc == 1, "R8 rise above 128", modeAcc, 1);
    secLevel = 11'd100; @(negedge clk);
    check(modeAcc == 1, "R9 hold mid", modeAcc, 1);
    secLevel = 11'd32; @(negedge clk);
    check(modeAcc == 1, "R9 hold at 32", modeAcc, 1);
    secLevel = 11'd31; @(negedge clk);
    check(modeAcc == 0, "R9 fall below 32", modeAcc, 0);
    secLevel = 11'd128; @(negedge clk);
    check(modeAcc == 0, "R9 stay low at 128", modeAcc, 0);
    secLevel = 11'd1000; @(negedge clk);
    check(modeAcc == 1, "R8 rise at high level", modeAcc, 1);

    check(srcRd == 0 && srcEmpty == 3'b111, "R2 idle when drained", {srcRd, srcEmpty}, 3'b111);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule